// File: doc/BRIEF.md
# Cache Control Register File

This block holds the software-visible control state for a processor's instruction and data caches. It has one writable 32-bit control word and two fixed, read-only configuration words. All three sit on a small word-wide register bus that carries an address, an access size, a write enable, write data and registered read data. The block only models register state. It drives no cache, flush engine, snoop logic or burst fetcher.

The control word holds a 2-bit state field for each cache: 00 means off, 01 means frozen and 11 means on. The instruction cache uses bits [1:0] and the data cache uses bits [3:2]. Two enable bits choose whether taking an interrupt freezes a running cache. Bit 4 covers the instruction cache and bit 5 covers the data cache. The processor pulses `irqTaken` for one cycle when it takes an interrupt, and every running cache whose enable bit is set moves to frozen. Command and status bits that have no storage meaning are cleared on every write.

Top module: `cache_ctl_regs`

## Requirements
- R1: Synchronous active-low reset clears the control word to zero (both caches off) and drives `busRdata` to zero.
- R2: A word write (`busSize`=2'b10, meaning 4 bytes) with `busWe` high to offset 0x00 stores the value on the clock edge. `busRdata` holds the addressed register one cycle after the address is presented, and shows the contents from before any write made in that cycle.
- R3: Bits 14, 15, 16, 21 and 22 are always stored as zero, whatever is written. Every other bit, including bit 23, is stored as written.
- R4: When `irqTaken` is high, bit 4 is set and bits [1:0] equal 11, bits [1:0] become 01 on the next edge.
- R5: When `irqTaken` is high, bit 5 is set and bits [3:2] equal 11, bits [3:2] become 01 on the next edge.
- R6: An interrupt leaves a state field unchanged if the field holds 00, 01 or 10, or if its freeze enable bit is clear. Without a write or an interrupt, the control word keeps its value.
- R7: If a control write and `irqTaken` fall in the same cycle, the written value is stored and no freeze is applied.
- R8: Offset 0x04 reads 0x10220000 and offset 0x08 reads 0x18220000. Writes to either offset change nothing.
- R9: Any access whose size is not 2'b10 reads zero and has no effect when written.
- R10: A word access to any offset other than 0x00, 0x04 or 0x08 reads zero and has no effect when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busAddr | input | ADDR_W (8) | Byte offset of the access |
| busSize | input | 2 | Access size: 00 byte, 01 half, 10 word, 11 double |
| busWe | input | 1 | Write enable |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data for the previous cycle's address |
| irqTaken | input | 1 | One-cycle pulse when the processor takes an interrupt |

## Verification
The embedded assertions check these properties on every cycle:
- the command and status bits stay at zero;
- the control word holds its value when there is neither a write nor an interrupt;
- a running, freeze-enabled field drops to frozen after an interrupt;
- a same-cycle write beats the freeze;
- the configuration constants and the zero reads for rejected accesses appear one cycle later.

Some behaviour only the bench's scenarios can show, because the state is visible only through reads at offset 0x00. This covers that fields holding 00, 01 or 10 survive an interrupt, that writes to read-only, unmapped or narrow targets leave the control word intact, and that bit 23 survives a write. A reference model compares the read data on every clock, both in these scenarios and in a long run of mixed random traffic.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  // Access size encoding on the register bus.
  localparam logic [1:0] SIZE_WORD = 2'b10;

  // Per-cache state encodings.
  localparam logic [1:0] ST_OFF    = 2'b00;
  localparam logic [1:0] ST_FROZEN = 2'b01;
  localparam logic [1:0] ST_ON     = 2'b11;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_ICFG = 2'd2,
    SEL_DCFG = 2'd3
  } rdSel_e;

  // Strobes from the decoder to the datapath.
  typedef struct packed {
    logic   wrCtrl;
    logic   irqEv;
    rdSel_e rdSel;
  } ccrStrobe_t;

endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
  import ccr_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [31:0] CTRL_OFF = 32'h00,
  parameter logic [31:0] ICFG_OFF = 32'h04,
  parameter logic [31:0] DCFG_OFF = 32'h08
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic              busWe,
  input  logic              irqTaken,
  output ccrStrobe_t        strb
);

  localparam logic [ADDR_W-1:0] A_CTRL = CTRL_OFF[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_ICFG = ICFG_OFF[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_DCFG = DCFG_OFF[ADDR_W-1:0];

  logic wordAcc;
  logic hitCtrl, hitIcfg, hitDcfg;

  assign wordAcc = (busSize == SIZE_WORD);
  assign hitCtrl = wordAcc && (busAddr == A_CTRL);
  assign hitIcfg = wordAcc && (busAddr == A_ICFG);
  assign hitDcfg = wordAcc && (busAddr == A_DCFG);

  always_comb begin
    strb.wrCtrl = busWe && hitCtrl;
    strb.irqEv  = irqTaken;
    if (hitCtrl)      strb.rdSel = SEL_CTRL;
    else if (hitIcfg) strb.rdSel = SEL_ICFG;
    else if (hitDcfg) strb.rdSel = SEL_DCFG;
    else              strb.rdSel = SEL_NONE;
  end

  // R9: a narrow access selects nothing and writes nothing.
  a_r9_narrow_rejected: assert property (@(posedge clk) disable iff (!rstN)
    (busSize != SIZE_WORD) |-> (!strb.wrCtrl && strb.rdSel == SEL_NONE));

  // R10: an unlisted offset selects nothing and writes nothing.
  a_r10_unmapped_rejected: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != A_CTRL && busAddr != A_ICFG && busAddr != A_DCFG)
      |-> (!strb.wrCtrl && strb.rdSel == SEL_NONE));

endmodule

// File: rtl/ccr_datapath.sv
module ccr_datapath
  import ccr_pkg::*;
#(
  parameter int          NUM_CACHES = 2,
  parameter logic [31:0] WR_MASK    = 32'h0061_C000,
  parameter logic [31:0] ICFG_VAL   = 32'h1022_0000,
  parameter logic [31:0] DCFG_VAL   = 32'h1822_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  ccrStrobe_t  strb,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata
);

  // Freeze-enable bits follow directly above the state fields.
  localparam int FRZ_BASE = 2 * NUM_CACHES;

  logic [31:0]           ctrlQ, ctrlFrz, ctrlD, rdNext;
  logic [NUM_CACHES-1:0] frzHit;

  for (genvar g = 0; g < NUM_CACHES; g++) begin : g_frz
    assign frzHit[g] = strb.irqEv && ctrlQ[FRZ_BASE + g] &&
                       (ctrlQ[2*g +: 2] == ST_ON);
  end

  always_comb begin
    ctrlFrz = ctrlQ;
    for (int i = 0; i < NUM_CACHES; i++) begin
      if (frzHit[i]) ctrlFrz[2*i +: 2] = ST_FROZEN;
    end
    ctrlD = strb.wrCtrl ? (busWdata & ~WR_MASK) : ctrlFrz;
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_CTRL: rdNext = ctrlQ;
      SEL_ICFG: rdNext = ICFG_VAL;
      SEL_DCFG: rdNext = DCFG_VAL;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      busRdata <= '0;
    end else begin
      ctrlQ    <= ctrlD;
      busRdata <= rdNext;
    end
  end

  // R3: command/status bits are never held.
  a_r3_cmd_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ & WR_MASK) == '0);

  // R4: running instruction cache with freeze enabled drops to frozen.
  a_r4_ifreeze: assert property (@(posedge clk) disable iff (!rstN)
    (strb.irqEv && !strb.wrCtrl && ctrlQ[FRZ_BASE] && ctrlQ[1:0] == ST_ON)
      |=> (ctrlQ[1:0] == ST_FROZEN));

  // R5: running data cache with freeze enabled drops to frozen.
  a_r5_dfreeze: assert property (@(posedge clk) disable iff (!rstN)
    (strb.irqEv && !strb.wrCtrl && ctrlQ[FRZ_BASE+1] && ctrlQ[3:2] == ST_ON)
      |=> (ctrlQ[3:2] == ST_FROZEN));

  // R6: no write and no interrupt keeps the control word.
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrCtrl && !strb.irqEv) |=> $stable(ctrlQ));

  // R7: a write beats a same-cycle freeze.
  a_r7_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCtrl && strb.irqEv) |=> (ctrlQ[3:0] == $past(busWdata[3:0])));

  // R8: configuration constants appear one cycle after selection.
  a_r8_icfg_value: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == SEL_ICFG) |=> (busRdata == ICFG_VAL));

  a_r8_dcfg_value: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == SEL_DCFG) |=> (busRdata == DCFG_VAL));

  // R9, R10: rejected accesses read zero.
  a_r10_zero_read: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == SEL_NONE) |=> (busRdata == '0));

endmodule

// File: rtl/cache_ctl_regs.sv
module cache_ctl_regs
  import ccr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              irqTaken
);

  ccrStrobe_t strb;

  ccr_decode #(
    .ADDR_W (ADDR_W)
  ) u_decode (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busSize  (busSize),
    .busWe    (busWe),
    .irqTaken (irqTaken),
    .strb     (strb)
  );

  ccr_datapath #(
    .NUM_CACHES (2)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .busRdata (busRdata)
  );

endmodule

// File: tb/cache_ctl_regs_test.sv
`timescale 1ns/1ps
module cache_ctl_regs_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  busAddr;
  logic [1:0]  busSize;
  logic        busWe;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic        irqTaken;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  string curReq = "R1";

  // Reference state
  logic [31:0] refCtrl;
  logic [31:0] refRd;

  always #2.5 clk = ~clk;

  cache_ctl_regs uut (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busSize  (busSize),
    .busWe    (busWe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irqTaken (irqTaken)
  );

  function automatic logic [31:0] readOf(logic [7:0] a, logic [1:0] s, logic [31:0] c);
    if (s != 2'b10) return 32'h0;
    case (a)
      8'h00:   return c;
      8'h04:   return 32'h1022_0000;
      8'h08:   return 32'h1822_0000;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: busRdata=%h expected=%h", curReq, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, model at posedge, compare at next negedge.
  task automatic cycle(logic [7:0] a, logic [1:0] s, logic we, logic [31:0] wd, logic irq);
    busAddr = a; busSize = s; busWe = we; busWdata = wd; irqTaken = irq;
    @(posedge clk);
    refRd = readOf(a, s, refCtrl);
    if (we && s == 2'b10 && a == 8'h00) begin
      refCtrl = wd & ~32'h0061_C000;
    end else if (irq) begin
      if (refCtrl[4] && refCtrl[1:0] == 2'b11) refCtrl[1:0] = 2'b01;
      if (refCtrl[5] && refCtrl[3:2] == 2'b11) refCtrl[3:2] = 2'b01;
    end
    @(negedge clk);
    check(busRdata, refRd);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    cycle(a, 2'b10, 1'b1, d, 1'b0);
  endtask

  task automatic rd(logic [7:0] a);
    cycle(a, 2'b10, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic irq();
    cycle(8'h40, 2'b10, 1'b0, 32'h0, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; busAddr = '0; busSize = 2'b10; busWe = 1'b0;
    busWdata = '0; irqTaken = 1'b0;
    refCtrl = '0;
    repeat (3) @(negedge clk);
    curReq = "R1";
    check(busRdata, 32'h0);
    rstN = 1'b1;
    rd(8'h00);
    rd(8'h00);

    curReq = "R2";                       // write then read back, latency
    wr(8'h00, 32'h0000_000F);
    rd(8'h00);
    wr(8'h00, 32'h0000_0003);            // read during write sees old value
    rd(8'h00);

    curReq = "R3";                       // masked bits and bit 23
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00);
    wr(8'h00, 32'h0080_0000);
    rd(8'h00);

    curReq = "R4";
    wr(8'h00, 32'h0000_001F);
    irq(); rd(8'h00);

    curReq = "R5";
    wr(8'h00, 32'h0000_002F);
    irq(); rd(8'h00);
    wr(8'h00, 32'h0000_003F);
    irq(); rd(8'h00);

    curReq = "R6";                       // enables clear; non-running fields
    wr(8'h00, 32'h0000_000F);
    irq(); rd(8'h00);
    wr(8'h00, 32'h0000_0032);
    irq(); rd(8'h00);
    wr(8'h00, 32'h0000_0034);
    irq(); rd(8'h00);
    rd(8'h00);

    curReq = "R7";
    cycle(8'h00, 2'b10, 1'b1, 32'h0000_003F, 1'b1);
    rd(8'h00);

    curReq = "R8";
    rd(8'h04); rd(8'h08);
    wr(8'h04, 32'hDEAD_BEEF);
    wr(8'h08, 32'h0000_0000);
    rd(8'h04); rd(8'h08); rd(8'h00);

    curReq = "R9";
    for (int s = 0; s < 4; s++) begin
      if (s == 2) continue;
      cycle(8'h00, 2'(s), 1'b1, 32'h0000_0000, 1'b0);
      cycle(8'h00, 2'(s), 1'b0, 32'h0, 1'b0);
      cycle(8'h04, 2'(s), 1'b0, 32'h0, 1'b0);
    end
    rd(8'h00);

    curReq = "R10";
    wr(8'h0C, 32'h0000_0000);
    wr(8'h01, 32'h0000_0000);
    rd(8'h0C); rd(8'h01); rd(8'h00);

    curReq = "R2";                       // mixed random traffic
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      case ($urandom_range(0, 4))
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
        default: a = 8'h00;
      endcase
      cycle(a, ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'b10,
            ($urandom_range(0, 2) == 0), $urandom() | 32'h0000_003C,
            ($urandom_range(0, 2) == 0));
    end

    curReq = "R1";                       // reset mid-run
    busWe = 1'b0; irqTaken = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    refCtrl = '0;
    check(busRdata, 32'h0);
    rstN = 1'b1;
    rd(8'h00); rd(8'h00);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule